// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits on the target side of a management bus, which is modelled here as a parallel register port, and gives a host access to a 32 by 32 space of internal 16-bit registers. The space is addressed by a 5-bit device number and a 5-bit register number. A strap input selects how the block answers:

- When the strap is zero, each host access (device, register) is passed straight through to the internal register port.
- When the strap is nonzero, the block answers at only that one device address. It exposes two registers there, a command word at index 0 and a data word at index 1. The host reaches the internal space through that pair.

To write in indirect mode, the host loads the data word and then writes a write command. To read, the host writes a read command, polls the command word until its top bit (busy) reads 0, and then reads the data word. The host checks that busy is clear before it issues any command, and gives up after 16 polls.

Host requests use valid/ready. A request is accepted on a clock edge where both `host_valid` and `host_ready` are high. In indirect mode `host_ready` is always high. In direct mode it is low from the acceptance edge until the internal access is acknowledged, which applies back-pressure for the variable latency of the internal port. Read responses come back as a single `host_rvalid` pulse. The response path has no back-pressure.

The internal port is a req/ack handshake. `int_req` is held with stable fields until it is sampled together with `int_ack`. It drops on the following edge.

Top module: `smi_indirect_bridge`

## Requirements
- R1: After reset, `cmd_busy`, `int_req` and `host_rvalid` are 0. In indirect mode `host_ready` is 1, and the command and data words read as 0x0000.
- R2: With the strap at zero, an accepted host access is issued on the internal port with the same device, register, direction and write data. `host_ready` stays low until the ack. For a read, `host_rvalid` pulses with `int_rdata` on the cycle after the ack edge.
- R3: With a nonzero strap, accesses to any other device address have no effect. Reads there return 0xFFFF.
- R4: At the strap address, an indirect read returns one cycle after acceptance. Index 0 returns {busy, bits 14:0 of the last launched command}, index 1 returns the data word, and any other index returns 0x0000.
- R5: A command word with bit 15 = 1, bit 12 = 1 and bits 11:10 = 2'b10 (0x9800 | dev<<5 | reg) starts one internal read of dev = bits 9:5 and reg = bits 4:0. Busy reads 1 from the next cycle.
- R6: A command word with bits 11:10 = 2'b01 (0x9400 | dev<<5 | reg) starts one internal write carrying the current data word.
- R7: A command word with bit 15 = 0, bit 12 = 0, or bits 11:10 equal to 2'b00 or 2'b11 is ignored. Busy stays 0, no internal request is made, and the data word is unchanged.
- R8: While busy is 1, host writes to the command and data words are dropped.
- R9: Read data is loaded into the data word on the ack edge. Busy is still 1 in the cycle after that edge and 0 in the cycle after that.
- R10: `int_req` holds its device, register, direction and data stable until the ack, and each launched command makes exactly one internal transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Device address strap; zero selects direct mode |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Bridge can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_phy | input | 5 | Device address of the host access |
| host_reg | input | 5 | Register index of the host access |
| host_wdata | input | 16 | Host write data |
| host_rvalid | output | 1 | Read response pulse |
| host_rdata | output | 16 | Read response data |
| cmd_busy | output | 1 | Indirect operation in flight |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_dev | output | 5 | Internal device number |
| int_reg | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_ack | input | 1 | Internal access complete |
| int_rdata | input | 16 | Internal read data, valid with ack |

## Verification
The bench walks valid and malformed command words: each bad opcode, a cleared mode bit and a cleared start bit. A decoder that is too lenient would set busy or launch a transaction the bench's counter sees. It issues writes to both registers during a long-latency operation and then reads back the data word, the command word and the written memory cell. A bridge that let writes through while busy would corrupt the transfer in flight. It pins busy to the exact two cycles around the ack edge, which catches a flag that clears early or lingers. It also covers direct pass-through and off-address accesses: a bridge that answered the wrong address, or failed to float reads there to all ones, would show up.

// File: rtl/smi_bridge_pkg.sv
package smi_bridge_pkg;
  parameter int unsigned SMI_AW = 5;
  parameter int unsigned SMI_DW = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/smi_cmd_decode.sv
module smi_cmd_decode #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic [DW-1:0] word,
  output logic          cmd_ok,
  output logic          cmd_we,
  output logic [AW-1:0] cmd_dev,
  output logic [AW-1:0] cmd_reg
);
  localparam int OP_LSB    = 2 * AW;
  localparam int MODE_BIT  = OP_LSB + 2;
  localparam int START_BIT = DW - 1;

  logic [1:0] op;
  logic       unused_spare;

  assign op           = word[OP_LSB+1:OP_LSB];
  assign unused_spare = ^word[START_BIT-1:MODE_BIT+1];
  assign cmd_ok  = word[START_BIT] && word[MODE_BIT] && (op == 2'b10 || op == 2'b01);
  assign cmd_we  = (op == 2'b01);
  assign cmd_dev = word[2*AW-1:AW];
  assign cmd_reg = word[AW-1:0];
endmodule

// File: rtl/smi_int_seq.sv
module smi_int_seq
  import smi_bridge_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_dev,
  input  logic [AW-1:0] start_reg,
  input  logic [DW-1:0] start_wdata,
  input  logic          linger,
  output logic          busy,
  output logic          int_req,
  output logic          int_we,
  output logic [AW-1:0] int_dev,
  output logic [AW-1:0] int_reg,
  output logic [DW-1:0] int_wdata,
  input  logic          int_ack
);
  seq_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      int_we    <= 1'b0;
      int_dev   <= '0;
      int_reg   <= '0;
      int_wdata <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          int_we    <= start_we;
          int_dev   <= start_dev;
          int_reg   <= start_reg;
          int_wdata <= start_wdata;
          state_q   <= SEQ_REQ;
        end
        SEQ_REQ:  if (int_ack) state_q <= linger ? SEQ_HOLD : SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign int_req = (state_q == SEQ_REQ);
  assign busy    = (state_q != SEQ_IDLE);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable(int_dev) && $stable(int_reg)
                               && $stable(int_we) && $stable(int_wdata)));
  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> !int_req);
endmodule

// File: rtl/smi_indirect_bridge.sv
module smi_indirect_bridge
  import smi_bridge_pkg::*;
#(
  parameter int AW = SMI_AW,
  parameter int DW = SMI_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [AW-1:0] host_phy,
  input  logic [AW-1:0] host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic          cmd_busy,
  output logic          int_req,
  output logic          int_we,
  output logic [AW-1:0] int_dev,
  output logic [AW-1:0] int_reg,
  output logic [DW-1:0] int_wdata,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata
);
  localparam logic [AW-1:0] CMD_IDX  = '0;
  localparam logic [AW-1:0] DATA_IDX = AW'(1);

  logic          direct, hit, fire, seq_busy, ack_fire;
  logic          cmd_ok, cmd_we, launch_ind, launch_dir, start;
  logic [AW-1:0] cmd_dev, cmd_reg;
  logic [DW-1:0] cmd_q, data_q, rd_mux;
  logic          unused_cmd_top;

  assign direct     = (strap_addr == '0);
  assign hit        = !direct && (host_phy == strap_addr);
  assign host_ready = direct ? !seq_busy : 1'b1;
  assign fire       = host_valid && host_ready;
  assign cmd_busy   = seq_busy && !direct;
  assign ack_fire   = int_req && int_ack;
  assign unused_cmd_top = cmd_q[DW-1];

  smi_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
    .word(host_wdata), .cmd_ok(cmd_ok), .cmd_we(cmd_we),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg)
  );

  assign launch_ind = fire && host_write && hit && (host_reg == CMD_IDX) && !seq_busy && cmd_ok;
  assign launch_dir = fire && direct;
  assign start      = launch_ind || launch_dir;

  smi_int_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_we   (direct ? host_write : cmd_we),
    .start_dev  (direct ? host_phy   : cmd_dev),
    .start_reg  (direct ? host_reg   : cmd_reg),
    .start_wdata(direct ? host_wdata : data_q),
    .linger(!direct), .busy(seq_busy),
    .int_req(int_req), .int_we(int_we), .int_dev(int_dev),
    .int_reg(int_reg), .int_wdata(int_wdata), .int_ack(int_ack)
  );

  always_comb begin
    if (!hit)                       rd_mux = '1;
    else if (host_reg == CMD_IDX)   rd_mux = {seq_busy, cmd_q[DW-2:0]};
    else if (host_reg == DATA_IDX)  rd_mux = data_q;
    else                            rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      data_q      <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= 1'b0;
      if (launch_ind) cmd_q <= host_wdata;
      if (fire && host_write && hit && (host_reg == DATA_IDX) && !seq_busy)
        data_q <= host_wdata;
      if (ack_fire && !int_we) begin
        if (direct) begin
          host_rvalid <= 1'b1;
          host_rdata  <= int_rdata;
        end else begin
          data_q <= int_rdata;
        end
      end
      if (fire && !host_write && !direct) begin
        host_rvalid <= 1'b1;
        host_rdata  <= rd_mux;
      end
    end
  end

  // R2
  direct_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && ack_fire && !int_we) |=> (host_rvalid && host_rdata == $past(int_rdata)));
  // R4
  ind_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !host_write && !direct) |=> host_rvalid);
  // R7
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && fire && host_write && hit && host_reg == CMD_IDX && !cmd_ok) |=> !seq_busy);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && fire && host_write && hit && !ack_fire) |=> ($stable(data_q) && $stable(cmd_q)));
  // R9
  busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && ack_fire) |=> (cmd_busy ##1 !cmd_busy));
endmodule

// File: tb/smi_indirect_bridge_tb.sv
module smi_indirect_bridge_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = 5'd17;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [4:0]  host_phy = '0, host_reg = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, host_rvalid, cmd_busy, int_req, int_we;
  logic [15:0] host_rdata, int_wdata;
  logic [4:0]  int_dev, int_reg;
  logic        int_ack = 1'b0;
  logic [15:0] int_rdata = '0;

  smi_indirect_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_phy(host_phy), .host_reg(host_reg), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .cmd_busy(cmd_busy),
    .int_req(int_req), .int_we(int_we), .int_dev(int_dev), .int_reg(int_reg),
    .int_wdata(int_wdata), .int_ack(int_ack), .int_rdata(int_rdata)
  );

  int checks = 0, errors = 0;
  int lat = 2, acnt = 0, txn = 0;
  logic [15:0] mem [32][32];
  logic [4:0]  last_dev, last_reg;
  logic        last_we;

  // Internal register space model with configurable latency
  always @(negedge clk) begin
    if (int_ack) int_ack = 1'b0;
    else if (int_req) begin
      if (acnt >= lat) begin
        int_ack = 1'b1; acnt = 0; txn++;
        last_dev = int_dev; last_reg = int_reg; last_we = int_we;
        if (int_we) mem[int_dev][int_reg] = int_wdata;
        else int_rdata = mem[int_dev][int_reg];
      end else acnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hx(input logic w, input logic [4:0] p, input logic [4:0] r,
                    input logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    host_valid = 1'b1; host_write = w; host_phy = p; host_reg = r; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    rd = 16'h0;
    if (!w) begin
      for (int n = 0; n < 50 && !host_rvalid; n++) @(negedge clk);
      rd = host_rvalid ? host_rdata : 16'hDEAD;
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    rst_n = 1'b0; strap_addr = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic poll_idle(output logic ok);
    logic [15:0] v;
    ok = 1'b0;
    for (int n = 0; n < 16 && !ok; n++) begin
      hx(1'b0, strap_addr, 5'd0, 16'h0, v);
      ok = !v[15];
    end
  endtask

  // {cmd[15:0], data[15:0], launches, is_write}
  localparam logic [33:0] VEC [9] = '{
    {16'h9867, 16'h0000, 1'b1, 1'b0},
    {16'h9522, 16'hBEEF, 1'b1, 1'b1},
    {16'h9922, 16'h0000, 1'b1, 1'b0},
    {16'h9122, 16'hA1A1, 1'b0, 1'b0},
    {16'h9D22, 16'hB2B2, 1'b0, 1'b0},
    {16'h8922, 16'hC3C3, 1'b0, 1'b0},
    {16'h1922, 16'hD4D4, 1'b0, 1'b0},
    {16'h97FF, 16'h1234, 1'b1, 1'b1},
    {16'h9BFF, 16'h0000, 1'b1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic ok;
    int t0;
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++)
        mem[d][r] = 16'h4000 ^ 16'(d << 5) ^ 16'(r) ^ 16'(d * r);

    // R1 reset state
    do_reset(5'd17);
    chk("R1 busy", cmd_busy, 0);
    chk("R1 req", int_req, 0);
    chk("R1 rvalid", host_rvalid, 0);
    chk("R1 ready", host_ready, 1);
    hx(1'b0, 5'd17, 5'd0, 16'h0, v); chk("R1 cmd word", v, 16'h0000);
    hx(1'b0, 5'd17, 5'd1, 16'h0, v); chk("R1 data word", v, 16'h0000);

    // Vector walk: R4 R5 R6 R7 R9 R10
    foreach (VEC[i]) begin
      logic [15:0] c, dw;
      logic [4:0]  dv, rg;
      c = VEC[i][33:18]; dw = VEC[i][17:2];
      dv = c[9:5]; rg = c[4:0];
      hx(1'b1, 5'd17, 5'd1, dw, v);
      t0 = txn;
      hx(1'b1, 5'd17, 5'd0, c, v);
      chk(VEC[i][1] ? "R5 busy set" : "R7 busy stays clear", cmd_busy, VEC[i][1]);
      poll_idle(ok);
      chk("R9 busy clears", ok, 1);
      chk("R10 one transaction", txn - t0, VEC[i][1] ? 1 : 0);
      if (VEC[i][1]) begin
        chk("R5 dev/reg", {last_dev, last_reg}, {dv, rg});
        chk("R6 direction", last_we, VEC[i][0]);
        hx(1'b0, 5'd17, 5'd0, 16'h0, v);
        chk("R4 cmd readback", v, {1'b0, c[14:0]});
        hx(1'b0, 5'd17, 5'd1, 16'h0, v);
        if (VEC[i][0]) begin
          chk("R6 memory written", mem[dv][rg], dw);
        end else begin
          chk("R9 read data", v, mem[dv][rg]);
        end
      end else begin
        hx(1'b0, 5'd17, 5'd1, 16'h0, v);
        chk("R7 data unchanged", v, dw);
      end
    end

    // R3 other device address
    hx(1'b1, 5'd17, 5'd1, 16'h3C3C, v);
    hx(1'b0, 5'd3, 5'd0, 16'h0, v); chk("R3 float read", v, 16'hFFFF);
    hx(1'b1, 5'd3, 5'd1, 16'h7777, v);
    t0 = txn;
    hx(1'b1, 5'd3, 5'd0, 16'h9867, v);
    chk("R3 no launch", cmd_busy, 0);
    hx(1'b0, 5'd17, 5'd1, 16'h0, v); chk("R3 data untouched", v, 16'h3C3C);
    chk("R3 no transaction", txn - t0, 0);

    // R4 unused index
    hx(1'b0, 5'd17, 5'd5, 16'h0, v); chk("R4 other index", v, 16'h0000);

    // R8 / R9 long latency
    lat = 10;
    hx(1'b1, 5'd17, 5'd1, 16'h1111, v);
    t0 = txn;
    hx(1'b1, 5'd17, 5'd0, 16'h9444, v);
    hx(1'b1, 5'd17, 5'd1, 16'h2222, v);
    hx(1'b1, 5'd17, 5'd0, 16'h9867, v);
    @(posedge clk);
    while (!int_ack) @(posedge clk);
    @(negedge clk);
    chk("R9 busy held after ack", cmd_busy, 1);
    chk("R10 req dropped", int_req, 0);
    @(negedge clk);
    chk("R9 busy cleared", cmd_busy, 0);
    chk("R8 write data kept", mem[2][4], 16'h1111);
    hx(1'b0, 5'd17, 5'd1, 16'h0, v); chk("R8 data word kept", v, 16'h1111);
    hx(1'b0, 5'd17, 5'd0, 16'h0, v); chk("R8 cmd word kept", v, 16'h1444);
    chk("R8 single transaction", txn - t0, 1);

    // R2 direct mode
    lat = 3;
    do_reset(5'd0);
    hx(1'b1, 5'd4, 5'd3, 16'h5A5A, v);
    chk("R2 ready low in flight", host_ready, 0);
    chk("R2 no busy flag", cmd_busy, 0);
    hx(1'b0, 5'd7, 5'd9, 16'h0, v);
    chk("R2 direct write", mem[4][3], 16'h5A5A);
    chk("R2 direct read", v, mem[7][9]);
    chk("R2 read dev/reg", {last_dev, last_reg, last_we}, {5'd7, 5'd9, 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule